// File: doc/BRIEF.md
# Bidirectional I/O Port with Per-Pin PWM Takeover

An 8-bit general-purpose I/O port controlled through a small synchronous register bus. Software sets a data latch, a per-pin direction mask, a per-pin pull-up mask and a per-pin PWM takeover mask. The block turns these into output-value, output-enable and pull-up controls for each pad.

The level on each pad is sampled through a two-stage synchronizer. A read of the data register returns a mix of sources chosen bit by bit. An output bit returns its latch value. An input bit returns the synchronized pad level.

Any pin can be handed to an external PWM waveform. When a pin is handed over, the takeover has priority over the direction and pull-up settings. The PWM generator itself is outside this block.

Top module: `gpio_pwm_port`

## Requirements
- R1: After reset the data, direction, pull-up and PWM takeover registers all read 0. Every pad then has output enable 0 and pull-up 0.
- R2: A write to the data register at offset 0x00 always updates the latch. A read of offset 0x00 returns, for each bit, the latch when its direction bit is 1 and the synchronized pad level when its direction bit is 0.
- R3: Writing the data register does not change the read-back of a bit whose direction bit is 0. That bit still returns the pad level.
- R4: A pad level change shows in the read of offset 0x00 after the second rising clock edge that follows it, and not after the first.
- R5: The direction register at offset 0x04 is readable and writable in all 8 bits.
- R6: The pull-up register at offset 0x08 is readable and writable. A pad's pull-up output equals its pull-up bit only when both its direction bit and its takeover bit are 0. Otherwise the pull-up output is 0.
- R7: A pin with direction bit 1 and takeover bit 0 has output enable 1, and its output value equals its latch bit.
- R8: A pin with direction 0, pull-up 0 and takeover 0 is high impedance, with output enable 0 and pull-up 0.
- R9: The PWM takeover register at offset 0x59 is readable and writable. A set bit gives its pad output enable 1, pull-up 0, and an output value equal to the matching PWM input, whatever the direction bit.
- R10: A read of any other offset returns 0. A write to any other offset changes no register.
- R11: Read data is combinational from the address, so it is valid in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register offset |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_i | input | 8 | Pad input levels |
| pwm_i | input | 8 | PWM waveforms, one per pin |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| pad_pu_o | output | 8 | Pad pull-up enables |

## Verification
The bench builds the block with its defaults: an 8-bit port, a two-stage synchronizer, and the offsets 0x00, 0x04, 0x08 and 0x59. With eight pins, mixed masks such as 0xF0 and 0x81 can place output, input, pulled-up and PWM pins in one port at the same time. Each pin's result can therefore be checked against its own mode. The two-stage depth fixes the read latency of R4, so the bench checks the read after one edge and after two.

// File: rtl/gpio_pwm_pkg.sv
package gpio_pwm_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PULL,
    SEL_PWM
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pwm_pkg::*;
#(
  parameter int              W        = 8,
  parameter int              AW       = 8,
  parameter logic [AW-1:0]   DATA_OFF = 'h00,
  parameter logic [AW-1:0]   DIR_OFF  = 'h04,
  parameter logic [AW-1:0]   PULL_OFF = 'h08,
  parameter logic [AW-1:0]   PWM_OFF  = 'h59
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  pin_sync_i,
  output logic [W-1:0]  data_q_o,
  output logic [W-1:0]  dir_q_o,
  output logic [W-1:0]  pull_q_o,
  output logic [W-1:0]  pwm_q_o,
  output logic [W-1:0]  rdata_o
);
  reg_sel_e sel;

  always_comb begin
    if (addr_i == DATA_OFF)      sel = SEL_DATA;
    else if (addr_i == DIR_OFF)  sel = SEL_DIR;
    else if (addr_i == PULL_OFF) sel = SEL_PULL;
    else if (addr_i == PWM_OFF)  sel = SEL_PWM;
    else                         sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '0;
      pull_q_o <= '0;
      pwm_q_o  <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_DATA: data_q_o <= wdata_i;
        SEL_DIR:  dir_q_o  <= wdata_i;
        SEL_PULL: pull_q_o <= wdata_i;
        SEL_PWM:  pwm_q_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  // output bits return the latch, input bits return the pad
  logic [W-1:0] data_rd;
  assign data_rd = (data_q_o & dir_q_o) | (pin_sync_i & ~dir_q_o);

  always_comb begin
    case (sel)
      SEL_DATA: rdata_o = data_rd;
      SEL_DIR:  rdata_o = dir_q_o;
      SEL_PULL: rdata_o = pull_q_o;
      SEL_PWM:  rdata_o = pwm_q_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] pull_i,
  input  logic [W-1:0] pwm_en_i,
  input  logic [W-1:0] pwm_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] pu_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    always_comb begin
      if (pwm_en_i[g]) begin
        out_o[g] = pwm_i[g];
        oe_o[g]  = 1'b1;
        pu_o[g]  = 1'b0;
      end else if (dir_i[g]) begin
        out_o[g] = data_i[g];
        oe_o[g]  = 1'b1;
        pu_o[g]  = 1'b0;
      end else begin
        out_o[g] = data_i[g];
        oe_o[g]  = 1'b0;
        pu_o[g]  = pull_i[g];
      end
    end
  end
endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port #(
  parameter int                  W           = 8,
  parameter int                  ADDR_W      = 8,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]   DATA_OFF    = 'h00,
  parameter logic [ADDR_W-1:0]   DIR_OFF     = 'h04,
  parameter logic [ADDR_W-1:0]   PULL_OFF    = 'h08,
  parameter logic [ADDR_W-1:0]   PWM_OFF     = 'h59
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  input  logic [W-1:0]      pwm_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      pad_pu_o
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] data_q, dir_q, pull_q, pwm_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_regs #(
    .W(W), .AW(ADDR_W),
    .DATA_OFF(DATA_OFF), .DIR_OFF(DIR_OFF), .PULL_OFF(PULL_OFF), .PWM_OFF(PWM_OFF)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .pin_sync_i (pin_sync),
    .data_q_o   (data_q),
    .dir_q_o    (dir_q),
    .pull_q_o   (pull_q),
    .pwm_q_o    (pwm_q),
    .rdata_o    (rdata_o)
  );

  gpio_pin_ctrl #(.W(W)) u_pins (
    .data_i   (data_q),
    .dir_i    (dir_q),
    .pull_i   (pull_q),
    .pwm_en_i (pwm_q),
    .pwm_i    (pwm_i),
    .out_o    (pad_out_o),
    .oe_o     (pad_oe_o),
    .pu_o     (pad_pu_o)
  );
endmodule

// File: rtl/gpio_pwm_port_chk.sv
module gpio_pwm_port_chk #(
  parameter int                W        = 8,
  parameter int                AW       = 8,
  parameter logic [AW-1:0]     DATA_OFF = 'h00,
  parameter logic [AW-1:0]     DIR_OFF  = 'h04,
  parameter logic [AW-1:0]     PULL_OFF = 'h08,
  parameter logic [AW-1:0]     PWM_OFF  = 'h59
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_o,
  input logic [W-1:0]  pwm_i,
  input logic [W-1:0]  pad_out_o,
  input logic [W-1:0]  pad_oe_o,
  input logic [W-1:0]  pad_pu_o,
  input logic [W-1:0]  data_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  pwm_q
);
  logic mapped;
  assign mapped = (addr_i == DATA_OFF) || (addr_i == DIR_OFF) ||
                  (addr_i == PULL_OFF) || (addr_i == PWM_OFF);

  always @(posedge clk_i)
    if (!rst_ni) AST_RST_CLEAR: assert ((pad_oe_o == '0) && (pad_pu_o == '0)); // R1

  AST_DATA_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == DATA_OFF) |=> data_q == $past(wdata_i)); // R2
  AST_DIR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == DIR_OFF) |=> dir_q == $past(wdata_i)); // R5
  AST_PU_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0); // R6
  AST_OUT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ data_q) & dir_q & ~pwm_q) == '0); // R7
  AST_PWM_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pad_out_o ^ pwm_i) & pwm_q) == '0) && ((pad_oe_o & pwm_q) == pwm_q)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0); // R10
endmodule

bind gpio_pwm_port gpio_pwm_port_chk #(
  .W(W), .AW(ADDR_W),
  .DATA_OFF(DATA_OFF), .DIR_OFF(DIR_OFF), .PULL_OFF(PULL_OFF), .PWM_OFF(PWM_OFF)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pwm_i     (pwm_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .pad_pu_o  (pad_pu_o),
  .data_q    (data_q),
  .dir_q     (dir_q),
  .pwm_q     (pwm_q)
);

// File: tb/gpio_pwm_port_tb_top.sv
module gpio_pwm_port_tb_top;
  localparam logic [7:0] A_DATA = 8'h00;
  localparam logic [7:0] A_DIR  = 8'h04;
  localparam logic [7:0] A_PULL = 8'h08;
  localparam logic [7:0] A_PWM  = 8'h59;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin = '0;
  logic [7:0] pwm = '0;
  logic [7:0] pad_out, pad_oe, pad_pu;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_pwm_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pwm_i(pwm),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_pin(logic [7:0] p);
    @(negedge clk);
    pin = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_DATA, v); check("R1 data", v, 8'h00);
    rd(A_DIR, v);  check("R1 dir", v, 8'h00);
    rd(A_PULL, v); check("R1 pull", v, 8'h00);
    rd(A_PWM, v);  check("R1 pwm", v, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'h00);
  endtask

  task automatic t_dir_rw();
    logic [7:0] v;
    wr(A_DIR, 8'h5A); rd(A_DIR, v); check("R5 dir 5A", v, 8'h5A);
    wr(A_DIR, 8'hFF); rd(A_DIR, v); check("R5 dir FF", v, 8'hFF);
    wr(A_PULL, 8'hC3);
    rd(A_PULL, v); check("R11 same-cycle pull", v, 8'hC3);
    rd(A_DIR, v);  check("R11 same-cycle dir", v, 8'hFF);
    wr(A_DIR, 8'h00); wr(A_PULL, 8'h00);
  endtask

  task automatic t_mixed_read();
    logic [7:0] v;
    wr(A_DIR, 8'hF0); wr(A_DATA, 8'h3C); set_pin(8'hA5);
    rd(A_DATA, v); check("R2 mixed read", v, 8'h35);
    check("R7 oe", pad_oe, 8'hF0);
    check("R7 out", pad_out & 8'hF0, 8'h30);
    check("R8 hi-z pu", pad_pu, 8'h00);
  endtask

  task automatic t_input_write();
    logic [7:0] v;
    wr(A_DIR, 8'h00); set_pin(8'h0F);
    wr(A_DATA, 8'hF0);
    rd(A_DATA, v); check("R3 input unaffected", v, 8'h0F);
    wr(A_DIR, 8'hFF);
    rd(A_DATA, v); check("R2 latch kept", v, 8'hF0);
    check("R7 out latch", pad_out, 8'hF0);
    wr(A_DIR, 8'h00);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    set_pin(8'h00);
    @(negedge clk); pin = 8'hFF; addr = A_DATA;
    @(posedge clk); #1; v = rdata; check("R4 one edge", v, 8'h00);
    @(posedge clk); #1; v = rdata; check("R4 two edges", v, 8'hFF);
  endtask

  task automatic t_pullup();
    logic [7:0] v;
    wr(A_DIR, 8'h0F); wr(A_PULL, 8'hFF);
    rd(A_PULL, v); check("R6 pull rd", v, 8'hFF);
    check("R6 pu inputs only", pad_pu, 8'hF0);
    wr(A_PULL, 8'h00);
    check("R8 pu off", pad_pu, 8'h00);
    check("R8 oe inputs off", pad_oe, 8'h0F);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    wr(A_DIR, 8'h00); wr(A_PULL, 8'hFF); wr(A_DATA, 8'h00);
    wr(A_PWM, 8'h81);
    rd(A_PWM, v); check("R9 pwm rd", v, 8'h81);
    @(negedge clk); pwm = 8'hFF; #1;
    check("R9 oe", pad_oe, 8'h81);
    check("R9 out high", pad_out & 8'h81, 8'h81);
    check("R9 pu", pad_pu, 8'h7E);
    pwm = 8'h00; #1;
    check("R9 out low", pad_out & 8'h81, 8'h00);
    wr(A_DIR, 8'hFF); wr(A_DATA, 8'hFF);
    pwm = 8'h7E; #1;
    check("R9 over dir", pad_out, 8'h7E);
    wr(A_PWM, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(A_DIR, 8'h33); wr(A_PULL, 8'h44); wr(A_PWM, 8'h00);
    wr(8'h10, 8'hFF); wr(8'h05, 8'hFF); wr(8'h58, 8'hFF);
    rd(8'h10, v); check("R10 rd 10", v, 8'h00);
    rd(8'h5A, v); check("R10 rd 5A", v, 8'h00);
    rd(A_DIR, v); check("R10 dir kept", v, 8'h33);
    rd(A_PULL, v); check("R10 pull kept", v, 8'h44);
    rd(A_PWM, v); check("R10 pwm kept", v, 8'h00);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_rw();
    t_mixed_read();
    t_input_write();
    t_latency();
    t_pullup();
    t_pwm();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule